// File: doc/BRIEF.md
# Interprocessor Mailbox

This peripheral lets several processors pass 32-bit words to one another through a set of independent mailboxes. Each mailbox is a small first-in first-out queue. A bus write to a mailbox's message register adds a word to the queue, and a bus read of the same register removes the oldest word. Two read-only registers per mailbox report whether the queue is full and how many words it holds.

Every user, meaning a processor that takes interrupts from the block, has its own event status word and its own enable word. Each mailbox owns two adjacent bits in both words. The lower bit is set whenever a word is accepted into that mailbox. The upper bit is set when a removal takes the mailbox out of the full state. Software acknowledges an event by writing ones to the status bits it wants to clear. Each user's interrupt output is high while any of its enabled events is pending.

A configuration register holds an auto-idle flag and an idle-mode field. Writing its soft-reset bit empties every mailbox and clears all events and enables over a short sequence. The soft-reset bit then clears itself, and a done flag in the system status register returns to 1.

Top module: `ipc_mailbox`

## Requirements
- R1: A word written to the message register of mailbox m (offset 0x040 + 4*m) is returned by later reads of the same offset in the order it was written, and up to FIFO_DEPTH (default 4) words are held.
- R2: A write to a full mailbox is dropped and leaves its contents unchanged. A read of an empty mailbox returns 0 and leaves it empty.
- R3: The register at 0x080 + 4*m reads 1 when mailbox m is full and 0 otherwise. The register at 0x0C0 + 4*m reads the number of words held, so it reads 0 exactly when the mailbox is empty.
- R4: For user u, the event status word is at 0x100 + 8*u and the enable word is at 0x104 + 8*u. Bit 2*m of every user's status is set on each accepted write to mailbox m. Bit 2*m+1 is set when a read takes mailbox m from full to not full.
- R5: Writing a 1 to a status bit clears it. Writing a 0 leaves the bit unchanged. A write to the enable word replaces it.
- R6: irq[u] is 1 exactly when some bit is set in both user u's status word and user u's enable word.
- R7: Writing a 1 to bit 1 of the configuration register (0x010) starts a soft reset lasting SRST_CYCLES (default 4) cycles. During that time, bit 1 of 0x010 reads 1, bit 0 of 0x014 reads 0, message reads return 0, and all bus writes and mailbox reads have no effect. Afterwards all mailboxes are empty, all status, enable and configuration bits are 0, and bit 0 of 0x014 reads 1.
- R8: The register at 0x000 reads REV_MAJOR in bits 7:4 and REV_MINOR in bits 3:0, with zeros above.
- R9: Outside a soft reset, a write to 0x010 stores bit 0 (auto-idle) and bits 4:3 (idle mode, where 2 means smart idle), and these read back at the same positions. Every other bit reads 0.
- R10: After the hardware reset, all mailboxes are empty, all status and enable bits are 0, irq is all zeros, and bit 0 of 0x014 reads 1.
- R11: A read of an offset that maps to no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; ignored when bus_wr is high |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| irq | output | NUM_USERS | One interrupt line per user |

## Verification
A wrong queue pointer or count shows up on the first read of the message register that follows it: the returned word is out of order or duplicated, or a stale word comes back where 0 was due. A lost or spurious event shows on the affected irq line in the cycle right after the access that caused it, as long as that event is enabled. A soft reset that ends early, ends late or clears too little shows on the done flag, on the message reads issued during the reset, or on the first status read after it. The bench therefore checks the interrupt lines on every clock, and checks the read data on every read against the expected value for that cycle.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam int REG_AW = 12;
   localparam logic [REG_AW-1:0] OFS_REV    = 12'h000;
   localparam logic [REG_AW-1:0] OFS_CFG    = 12'h010;
   localparam logic [REG_AW-1:0] OFS_STAT   = 12'h014;
   localparam logic [REG_AW-1:0] OFS_MSG    = 12'h040;
   localparam logic [REG_AW-1:0] OFS_FULL   = 12'h080;
   localparam logic [REG_AW-1:0] OFS_LEVEL  = 12'h0C0;
   localparam logic [REG_AW-1:0] OFS_EVT    = 12'h100;
   localparam int BIT_AUTOIDLE = 0;
   localparam int BIT_SRST     = 1;

   typedef enum logic [1:0] {
      IDLE_FORCED = 2'd0,
      IDLE_NEVER  = 2'd1,
      IDLE_SMART  = 2'd2,
      IDLE_RSVD   = 2'd3
   } idle_mode_e;

   typedef struct packed {
      idle_mode_e idle;
      logic       autoidle;
   } cfg_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         flush,
   input  logic                         push,
   input  logic                         pop,
   input  logic [W-1:0]                 wdata,
   output logic [W-1:0]                 head,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         full,
   output logic                         push_ok,
   output logic                         pop_from_full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH+1);

   logic [W-1:0]  store [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          pop_ok;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
   endfunction

   assign full          = (level == CW'(DEPTH));
   assign push_ok       = push & ~full & ~flush;
   assign pop_ok        = pop & (level != '0) & ~flush;
   assign pop_from_full = pop_ok & full;
   assign head          = (level != '0) ? store[rp] : '0;

   always_ff @(posedge clk) begin
      if (push_ok) store[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (push_ok) wp <= nxt(wp);
         if (pop_ok)  rp <= nxt(rp);
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/mbox_user_irq.sv
module mbox_user_irq #(
   parameter int EW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic [EW-1:0] events,
   input  logic          st_wr,
   input  logic          en_wr,
   input  logic [EW-1:0] wdata,
   output logic [EW-1:0] status,
   output logic [EW-1:0] enable,
   output logic          irq
);
   logic [EW-1:0] ack;

   assign ack = st_wr ? wdata : '0;
   assign irq = |(status & enable);

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         status <= '0;
         enable <= '0;
      end else begin
         status <= (status & ~ack) | events;
         if (en_wr) enable <= wdata;
      end
   end
endmodule

// File: rtl/mbox_srst.sv
module mbox_srst #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int CW = $clog2(CYCLES+1);
   logic [CW-1:0] remain;

   assign busy = (remain != '0);

   always_ff @(posedge clk) begin
      if (!rst_n)           remain <= '0;
      else if (busy)        remain <= remain - 1'b1;
      else if (start)       remain <= CW'(CYCLES);
   end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox #(
   parameter int NUM_BOXES   = 4,
   parameter int NUM_USERS   = 2,
   parameter int FIFO_DEPTH  = 4,
   parameter int DATA_W      = 32,
   parameter int SRST_CYCLES = 4,
   parameter int REV_MAJOR   = 2,
   parameter int REV_MINOR   = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic                 bus_rd,
   input  logic [11:0]          bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic [NUM_USERS-1:0] irq
);
   import mbox_pkg::*;

   localparam int EW = 2 * NUM_BOXES;
   localparam int CW = $clog2(FIFO_DEPTH+1);

   if (NUM_BOXES < 1 || NUM_BOXES > 16) begin : g_bad_boxes
      $error("NUM_BOXES must be 1..16");
   end
   if (NUM_USERS < 1 || NUM_USERS > 32) begin : g_bad_users
      $error("NUM_USERS must be 1..32");
   end
   if (DATA_W != 32) begin : g_bad_width
      $error("DATA_W must equal the 32-bit register bus");
   end
   if (FIFO_DEPTH < 1 || SRST_CYCLES < 1) begin : g_bad_depth
      $error("FIFO_DEPTH and SRST_CYCLES must be positive");
   end

   logic                            rst_busy, wr_en, rd_en, srst_start;
   logic [NUM_BOXES-1:0]            push_vec, pop_vec, fifo_full, push_ok, pop_full;
   logic [NUM_BOXES-1:0][DATA_W-1:0] head_arr;
   logic [NUM_BOXES-1:0][CW-1:0]    cnt_flat;
   logic [EW-1:0]                   events;
   logic [NUM_USERS-1:0]            st_wr, en_wr;
   logic [NUM_USERS-1:0][EW-1:0]    stat_arr, en_arr;
   cfg_t                            cfg_q;

   assign wr_en      = bus_wr & ~rst_busy;
   assign rd_en      = bus_rd & ~bus_wr & ~rst_busy;
   assign srst_start = wr_en && bus_addr == OFS_CFG && bus_wdata[BIT_SRST];

   mbox_srst #(.CYCLES(SRST_CYCLES)) srst_i (
      .clk(clk), .rst_n(rst_n), .start(srst_start), .busy(rst_busy)
   );

   for (genvar m = 0; m < NUM_BOXES; m++) begin : g_box
      localparam logic [11:0] MSG_A = OFS_MSG + 12'(4*m);
      assign push_vec[m] = wr_en && bus_addr == MSG_A;
      assign pop_vec[m]  = rd_en && bus_addr == MSG_A;
      assign events[2*m]   = push_ok[m];
      assign events[2*m+1] = pop_full[m];

      mbox_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) fifo_i (
         .clk(clk), .rst_n(rst_n), .flush(rst_busy),
         .push(push_vec[m]), .pop(pop_vec[m]), .wdata(bus_wdata),
         .head(head_arr[m]), .level(cnt_flat[m]), .full(fifo_full[m]),
         .push_ok(push_ok[m]), .pop_from_full(pop_full[m])
      );
   end

   for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
      assign st_wr[u] = wr_en && bus_addr == OFS_EVT + 12'(8*u);
      assign en_wr[u] = wr_en && bus_addr == OFS_EVT + 12'(8*u + 4);

      mbox_user_irq #(.EW(EW)) uirq_i (
         .clk(clk), .rst_n(rst_n), .flush(rst_busy), .events(events),
         .st_wr(st_wr[u]), .en_wr(en_wr[u]), .wdata(bus_wdata[EW-1:0]),
         .status(stat_arr[u]), .enable(en_arr[u]), .irq(irq[u])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n || srst_start)
         cfg_q <= '0;
      else if (wr_en && bus_addr == OFS_CFG)
         cfg_q <= '{idle: idle_mode_e'(bus_wdata[4:3]), autoidle: bus_wdata[BIT_AUTOIDLE]};
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (bus_addr == OFS_REV)
            bus_rdata = {24'd0, 4'(REV_MAJOR), 4'(REV_MINOR)};
         if (bus_addr == OFS_CFG)
            bus_rdata = {27'd0, cfg_q.idle, 1'b0, rst_busy, cfg_q.autoidle};
         if (bus_addr == OFS_STAT)
            bus_rdata = {31'd0, ~rst_busy};
         for (int m = 0; m < NUM_BOXES; m++) begin
            if (bus_addr == OFS_MSG + 12'(4*m))
               bus_rdata = rst_busy ? '0 : head_arr[m];
            if (bus_addr == OFS_FULL + 12'(4*m))
               bus_rdata = {31'd0, fifo_full[m]};
            if (bus_addr == OFS_LEVEL + 12'(4*m))
               bus_rdata = 32'(cnt_flat[m]);
         end
         for (int u = 0; u < NUM_USERS; u++) begin
            if (bus_addr == OFS_EVT + 12'(8*u))
               bus_rdata = 32'(stat_arr[u]);
            if (bus_addr == OFS_EVT + 12'(8*u + 4))
               bus_rdata = 32'(en_arr[u]);
         end
      end
   end
endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
   parameter int NB    = 4,
   parameter int NU    = 2,
   parameter int DEPTH = 4,
   parameter int CW    = $clog2(DEPTH+1),
   parameter int EW    = 2*NB
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_wr,
   input logic                   bus_rd,
   input logic [11:0]            bus_addr,
   input logic [31:0]            bus_wdata,
   input logic [NU-1:0]          irq,
   input logic                   busy,
   input logic [NB-1:0]          full,
   input logic [NB-1:0]          push,
   input logic [NB-1:0]          pop,
   input logic [NB-1:0][CW-1:0]  cnt,
   input logic [NU-1:0][EW-1:0]  stat
);
   // R7
   srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == 12'h010 && bus_wdata[1] && !busy) |=> busy);

   // R7
   srst_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (irq == '0));

   for (genvar m = 0; m < NB; m++) begin : g_box
      // R2
      full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (push[m] && full[m]) |=> (full[m] && cnt[m] == CW'(DEPTH)));
      // R2
      empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pop[m] && cnt[m] == '0) |=> (cnt[m] == '0));
      // R4
      newmsg_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (push[m] && !full[m]) |=> stat[0][2*m]);
      // R3
      always @(posedge clk) begin
         if (rst_n) level_bound_chk: assert (cnt[m] <= CW'(DEPTH));
      end
   end

   for (genvar u = 0; u < NU; u++) begin : g_user
      // R6
      irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq[u]) |-> $past(bus_wr || bus_rd));
   end
endmodule

bind ipc_mailbox mbox_chk #(
   .NB(NUM_BOXES), .NU(NUM_USERS), .DEPTH(FIFO_DEPTH)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq(irq),
   .busy(rst_busy), .full(fifo_full), .push(push_vec), .pop(pop_vec),
   .cnt(cnt_flat), .stat(stat_arr)
);

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NB = 4, NU = 2, DEPTH = 4, SRST = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NU-1:0] irq;

   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;

   ipc_mailbox dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // behavioural reference state
   int unsigned q [NB][$];
   logic [7:0]  mst [NU];
   logic [7:0]  men [NU];
   logic [31:0] mcfg;
   int          mbusy;

   function automatic logic [11:0] a_msg(int m);  return 12'h040 + 12'(4*m); endfunction
   function automatic logic [11:0] a_full(int m); return 12'h080 + 12'(4*m); endfunction
   function automatic logic [11:0] a_lvl(int m);  return 12'h0C0 + 12'(4*m); endfunction
   function automatic logic [11:0] a_st(int u);   return 12'h100 + 12'(8*u); endfunction
   function automatic logic [11:0] a_en(int u);   return 12'h104 + 12'(8*u); endfunction

   function automatic logic [31:0] mread(logic [11:0] a);
      if (a == 12'h000) return 32'h21;
      if (a == 12'h010) return mcfg | ((mbusy > 0) ? 32'h2 : 32'h0);
      if (a == 12'h014) return (mbusy == 0) ? 32'h1 : 32'h0;
      for (int m = 0; m < NB; m++) begin
         if (a == a_msg(m))  return (mbusy > 0 || q[m].size() == 0) ? 32'h0 : q[m][0];
         if (a == a_full(m)) return (q[m].size() == DEPTH) ? 32'h1 : 32'h0;
         if (a == a_lvl(m))  return 32'(q[m].size());
      end
      for (int u = 0; u < NU; u++) begin
         if (a == a_st(u)) return 32'(mst[u]);
         if (a == a_en(u)) return 32'(men[u]);
      end
      return 32'h0;
   endfunction

   function automatic logic [31:0] mirq();
      logic [31:0] r = '0;
      for (int u = 0; u < NU; u++) r[u] = |(mst[u] & men[u]);
      return r;
   endfunction

   task automatic mstep(bit w, bit r, logic [11:0] a, logic [31:0] d);
      if (mbusy > 0) begin
         for (int m = 0; m < NB; m++) q[m].delete();
         for (int u = 0; u < NU; u++) begin mst[u] = '0; men[u] = '0; end
         mbusy--;
         return;
      end
      if (w) begin
         if (a == 12'h010) begin
            if (d[1]) begin mbusy = SRST; mcfg = '0; end
            else mcfg = d & 32'h19;
         end
         for (int m = 0; m < NB; m++)
            if (a == a_msg(m) && q[m].size() < DEPTH) begin
               q[m].push_back(d);
               for (int u = 0; u < NU; u++) mst[u][2*m] = 1'b1;
            end
         for (int u = 0; u < NU; u++) begin
            if (a == a_st(u)) mst[u] = mst[u] & ~d[7:0];
            if (a == a_en(u)) men[u] = d[7:0];
         end
      end else if (r) begin
         for (int m = 0; m < NB; m++)
            if (a == a_msg(m) && q[m].size() > 0) begin
               bit wasfull = (q[m].size() == DEPTH);
               void'(q[m].pop_front());
               if (wasfull) for (int u = 0; u < NU; u++) mst[u][2*m+1] = 1'b1;
            end
      end
   endtask

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // one bus cycle, entered and left at a falling edge
   task automatic op(bit w, bit r, logic [11:0] a, logic [31:0] d, string tag);
      bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
      #1;
      if (r) check(tag, bus_rdata, mread(a));
      mstep(w, r, a, d);
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      check("R6 irq", 32'(irq), mirq());
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d); op(1, 0, a, d, "wr"); endtask
   task automatic rd(logic [11:0] a, string tag);     op(0, 1, a, 32'h0, tag); endtask
   task automatic idle(int n); repeat (n) op(0, 0, 12'h0, 32'h0, "idle"); endtask

   initial begin
      for (int u = 0; u < NU; u++) begin mst[u] = '0; men[u] = '0; end
      mcfg = '0; mbusy = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R10 irq after reset", 32'(irq), 32'h0);

      // R10 / R8 / R11 reset view
      rd(12'h000, "R8 revision");
      rd(12'h014, "R10 reset done");
      rd(12'h010, "R10 cfg zero");
      for (int m = 0; m < NB; m++) rd(a_lvl(m), "R10 level zero");
      rd(a_st(1), "R10 status zero");
      rd(12'h020, "R11 unmapped");
      rd(12'h0FC, "R11 unmapped");

      // R4 enables
      wr(a_en(0), 32'hFF);
      wr(a_en(1), 32'h01);
      rd(a_en(0), "R4 enable readback");

      // R1 R2 R3: overfill mailbox 0
      for (int i = 0; i < 5; i++) wr(a_msg(0), 32'hA000_0000 + 32'(i));
      rd(a_full(0), "R3 full flag");
      rd(a_lvl(0), "R3 level at depth");
      rd(a_st(0), "R4 new-message status");
      rd(a_st(1), "R4 status in every user");

      // R5 acknowledge
      wr(a_st(0), 32'h0);
      rd(a_st(0), "R5 zero write no effect");
      wr(a_st(0), 32'h1);
      rd(a_st(0), "R5 one clears");
      rd(a_st(1), "R5 other user untouched");
      wr(a_st(1), 32'hFF);

      // R1 order, R4 not-full, R2 empty pop
      for (int i = 0; i < 5; i++) rd(a_msg(0), "R1 pop order");
      rd(a_st(0), "R4 not-full status");
      rd(a_lvl(0), "R3 level empty");
      rd(a_full(0), "R3 not full");
      rd(a_msg(0), "R2 empty pop returns zero");
      rd(a_lvl(0), "R2 empty pop no change");

      // interleaved traffic on mailboxes 2 and 3
      wr(a_st(0), 32'hFF);
      wr(a_msg(3), 32'h3333_0001);
      wr(a_msg(2), 32'h2222_0001);
      wr(a_msg(3), 32'h3333_0002);
      rd(a_lvl(3), "R3 level mailbox 3");
      rd(a_msg(2), "R1 mailbox 2");
      rd(a_msg(3), "R1 mailbox 3 first");
      rd(a_msg(3), "R1 mailbox 3 second");
      wr(a_en(0), 32'h00);
      wr(a_en(0), 32'h40);

      // R9 configuration fields
      wr(12'h010, 32'h0000_0019);
      rd(12'h010, "R9 cfg readback");
      wr(12'h010, 32'hFFFF_FFFD);
      rd(12'h010, "R9 cfg masked");
      wr(12'h010, 32'h0000_0010);
      rd(12'h010, "R9 smart idle");

      // R7 soft reset with traffic pending
      wr(a_en(1), 32'hFF);
      for (int i = 0; i < 4; i++) wr(a_msg(1), 32'hB000_0000 + 32'(i));
      wr(a_msg(2), 32'hC0DE_0000);
      wr(12'h010, 32'h0000_0003);
      rd(12'h010, "R7 reset bit reads one");
      rd(12'h014, "R7 done flag low");
      rd(a_msg(1), "R7 message read blocked");
      wr(a_msg(0), 32'hDEAD_BEEF);
      idle(2);
      rd(12'h014, "R7 done flag back");
      rd(12'h010, "R7 cfg cleared");
      rd(a_lvl(0), "R7 write during reset ignored");
      rd(a_lvl(1), "R7 mailbox flushed");
      rd(a_msg(2), "R7 mailbox flushed");
      rd(a_st(1), "R7 status cleared");
      rd(a_en(1), "R7 enable cleared");
      wr(a_en(1), 32'h04);
      wr(a_msg(2), 32'h1234_5678);
      rd(a_msg(2), "R1 after soft reset");
      idle(2);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule